// File: doc/BRIEF.md
# Direct-Mapped Single-Word Data Cache

This block sits between a processor's load/store port and a slower, word-wide memory. It holds 64 lines of one 32-bit word each, for a total of 256 bytes. Every byte address maps to exactly one line. The two lowest bits pick a byte within the word, the next six bits pick the line, and the upper 24 bits are kept with the line as its tag. A lookup is a hit when the line is valid and its stored tag equals the upper address bits. Anything else is a miss, and the cache then goes to memory before it completes the access.

The processor side uses a valid/ready handshake. Hits complete in the cycle they are presented. On a miss, ready stays low until the memory work is done. Stores carry a 4-bit byte enable. A store that misses first brings the word into the cache and then merges the enabled bytes into it.

A static parameter selects the write policy:
- **Write-through:** every store also writes the merged word to memory.
- **Write-back:** a store touches only the cache and marks the line dirty. A dirty line is written back to memory before it is refilled with a different word.

The memory side is a request/acknowledge port. The request stays asserted for as many cycles as memory needs to answer.

Top module: `dm_dcache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses; with no processor request pending, `mem_req` stays low.
- R2: Address bits 7:2 select the line and bits 31:8 form the tag; bits 1:0 do not take part in the lookup, so two addresses that differ only there hit the same word.
- R3: A lookup hits when the selected line is valid and its tag matches. A read hit raises `cpu_ready` in the same cycle with the stored word on `cpu_rdata` and issues no memory request. `cpu_hit` is high with `cpu_ready` exactly when the first lookup of that access hit.
- R4: A read miss issues a memory read (`mem_we`=0) at the word address (bits 1:0 zero), installs the returned word with the new tag and valid set, and returns it in the cycle after the acknowledge with `cpu_hit` low.
- R5: `cpu_ready` stays low from the cycle a miss is detected until the memory work completes. A memory request holds its address and direction until acknowledged. With an acknowledge latency of L cycles after the request rises, a clean read miss stalls for L+2 cycles.
- R6: A store changes only the bytes whose enable bit is set; enable bit i covers data bits 8i+7 to 8i.
- R7: In write-through mode every store, hit or miss, updates the cached word and writes the full merged word to memory at the word address. It completes in the cycle of that write's acknowledge.
- R8: In write-back mode a store hit updates only the cache, completes in the same cycle, causes no memory traffic and marks the line dirty.
- R9: In write-back mode, a miss on a valid dirty line first writes the old word to the address rebuilt from the old tag and the line index, and then reads the new word. A dirty miss with latency L stalls for 2L+3 cycles.
- R10: Replacing a clean line, and any replacement in write-through mode, causes no memory write. A store miss allocates the line before merging.
- R11: From reset, word addresses 22, 26, 22, 26, 16, 3, 16, 18 are placed so that word w uses line w mod 8 and tag w div 8. They give miss, miss, hit, hit, miss, miss, hit, miss; the last is a tag mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access pending |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Byte enables for a store |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on loads |
| cpu_hit | output | 1 | Completed access hit on its first lookup |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request done this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The properties assume the processor keeps `cpu_valid`, the address and the direction steady from the cycle it raises valid until the cycle ready is seen. They also assume memory raises `mem_ack` only while a request is up and presents read data in that same cycle. The bench's driver keeps each access fixed until it observes ready and drops valid only after that edge. Its memory models answer combinationally after a programmable count of request cycles. The latency is varied between accesses but never changes while a request is open.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Controller states: lookup, old-word writeback, refill, write-through push
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_PUSH  = 2'd3
  } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-OFF_W-1:0] word_addr,
  output logic [IDX_W-1:0]        idx,
  output logic [TAG_W-1:0]        tag
);

  // The word address drops the byte offset; the line index sits just above it.
  assign idx = word_addr[IDX_W-1:0];
  assign tag = word_addr[ADDR_W-OFF_W-1:IDX_W];

endmodule

// File: rtl/dmc_merge.sv
module dmc_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [BYTES-1:0]  be,
  output logic [DATA_W-1:0] merged
);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = be[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
  end

endmodule

// File: rtl/dmc_lines.sv
module dmc_lines #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Status bits need a known reset; tag and data do not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= wr_tag;
      data_q[idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_valid,
  input  logic cpu_we,
  input  logic hit,
  input  logic line_valid,
  input  logic line_dirty,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic cpu_hit,
  output logic mem_req,
  output logic mem_we,
  output logic sel_evict,
  output logic arr_we,
  output logic arr_fill,
  output logic arr_dirty
);

  dmc_state_e state_q, state_d;
  logic       missed_q, missed_d;
  logic       miss_seen;

  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    sel_evict = 1'b0;
    arr_we    = 1'b0;
    arr_fill  = 1'b0;
    arr_dirty = 1'b0;
    miss_seen = 1'b0;
    unique case (state_q)
      ST_LOOK: begin
        if (cpu_valid) begin
          if (hit) begin
            if (cpu_we && !WRITE_BACK) begin
              state_d = ST_PUSH;
            end else begin
              cpu_ready = 1'b1;
              arr_we    = cpu_we;
              arr_dirty = cpu_we;
            end
          end else begin
            miss_seen = 1'b1;
            state_d   = (WRITE_BACK && line_valid && line_dirty) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        sel_evict = 1'b1;
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          arr_we   = 1'b1;
          arr_fill = 1'b1;
          state_d  = ST_LOOK;
        end
      end
      ST_PUSH: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          arr_we    = 1'b1;
          state_d   = ST_LOOK;
        end
      end
      default: state_d = ST_LOOK;
    endcase
  end

  always_comb begin
    missed_d = missed_q;
    if (miss_seen)      missed_d = 1'b1;
    else if (cpu_ready) missed_d = 1'b0;
  end

  assign cpu_hit = cpu_ready && !missed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_LOOK;
      missed_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      missed_q <= missed_d;
    end
  end

endmodule

// File: rtl/dm_dcache.sv
module dm_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter bit WRITE_BACK = 1'b1,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [BYTES-1:0]  cpu_be,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              line_valid;
  logic              line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic [DATA_W-1:0] merged;
  logic              hit;
  logic              sel_evict;
  logic              arr_we;
  logic              arr_fill;
  logic              arr_dirty;

  dmc_addr_split #(
    .ADDR_W (ADDR_W),
    .LINES  (LINES),
    .DATA_W (DATA_W)
  ) u_split (
    .word_addr (cpu_addr[ADDR_W-1:OFF_W]),
    .idx       (req_idx),
    .tag       (req_tag)
  );

  dmc_lines #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .idx      (req_idx),
    .rd_valid (line_valid),
    .rd_dirty (line_dirty),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (arr_we),
    .wr_tag   (req_tag),
    .wr_data  (arr_fill ? mem_rdata : merged),
    .wr_dirty (arr_dirty)
  );

  dmc_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .old_word (line_data),
    .new_word (cpu_wdata),
    .be       (cpu_be),
    .merged   (merged)
  );

  assign hit = line_valid && (line_tag == req_tag);

  dmc_ctrl #(
    .WRITE_BACK (WRITE_BACK)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .hit        (hit),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .mem_ack    (mem_ack),
    .cpu_ready  (cpu_ready),
    .cpu_hit    (cpu_hit),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .sel_evict  (sel_evict),
    .arr_we     (arr_we),
    .arr_fill   (arr_fill),
    .arr_dirty  (arr_dirty)
  );

  assign mem_addr  = sel_evict ? {line_tag, req_idx, {OFF_W{1'b0}}}
                               : {req_tag,  req_idx, {OFF_W{1'b0}}};
  assign mem_wdata = sel_evict ? line_data : merged;
  assign cpu_rdata = line_data;

endmodule

// File: rtl/dmc_sva.sv
module dmc_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);

  // R1: no memory traffic without a pending processor access
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> !mem_req);

  // R3: completion only for a pending access
  p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  // R3: a read hit needs no memory
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_hit && !cpu_we |-> !mem_req);

  // R4: refilled read word is returned on the next cycle, flagged as a miss
  p_read_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we && !cpu_we |=> cpu_ready && !cpu_hit);

  // R5: memory request held steady until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: input assumption - processor holds its access while stalled
  p_cpu_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_ready |=> cpu_valid && $stable(cpu_addr) && $stable(cpu_we));

  // R9: a writeback of an old word is followed directly by the refill read
  p_evict_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && !cpu_ready |=> mem_req && !mem_we);

endmodule

bind dm_dcache dmc_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_ready (cpu_ready),
  .cpu_hit   (cpu_hit),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/dm_dcache_test.sv
module dmc_test_mem (
  input  logic        clk,
  input  logic [3:0]  lat,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] mem [1024];
  int          cnt;
  int          wr_cnt;
  int          rd_cnt;
  logic [31:0] last_rd;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 + i;
    cnt = 0; wr_cnt = 0; rd_cnt = 0; last_rd = '0;
  end

  assign ack   = req && (cnt == int'(lat));
  assign rdata = mem[addr[11:2]];

  always @(posedge clk) begin
    if (req) begin
      if (ack) begin
        cnt <= 0;
        if (we) begin
          mem[addr[11:2]] <= wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt  <= rd_cnt + 1;
          last_rd <= addr;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module dm_dcache_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] d;
    logic        h;
    logic        cd;
    string       rq;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [3:0]  lat;
  logic        cv   [2];
  logic        cwe  [2];
  logic [3:0]  cbe  [2];
  logic [31:0] ca   [2];
  logic [31:0] cwd  [2];
  logic        crdy [2];
  logic [31:0] crd  [2];
  logic        chit [2];
  logic        mreq [2];
  logic        mwe  [2];
  logic [31:0] maddr[2];
  logic [31:0] mwd  [2];
  logic        mack [2];
  logic [31:0] mrd  [2];

  logic [31:0] shadow [2][1024];
  exp_t        q[$];
  exp_t        got;
  int          sel;
  int          checks;
  int          errors;

  dm_dcache #(.WRITE_BACK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_we(cwe[0]), .cpu_be(cbe[0]),
    .cpu_addr(ca[0]), .cpu_wdata(cwd[0]), .cpu_ready(crdy[0]), .cpu_rdata(crd[0]),
    .cpu_hit(chit[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
    .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]));

  dm_dcache #(.WRITE_BACK(1'b0)) uut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_we(cwe[1]), .cpu_be(cbe[1]),
    .cpu_addr(ca[1]), .cpu_wdata(cwd[1]), .cpu_ready(crdy[1]), .cpu_rdata(crd[1]),
    .cpu_hit(chit[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
    .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]));

  dmc_test_mem m0 (.clk(clk), .lat(lat), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]),
                   .wdata(mwd[0]), .ack(mack[0]), .rdata(mrd[0]));
  dmc_test_mem m1 (.clk(clk), .lat(lat), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]),
                   .wdata(mwd[1]), .ack(mack[1]), .rdata(mrd[1]));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // Word w placed on line w mod 8 with tag w div 8
  function automatic logic [31:0] wa(input int w);
    return (32'(w / 8) << 8) | (32'(w % 8) << 2);
  endfunction

  // Monitor: pops the expected item when a handshake completes
  always @(negedge clk) begin
    if (rst_n && cv[sel] && crdy[sel]) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3 unexpected completion", 32'd1, 32'd0);
      end else begin
        got = q.pop_front();
        chk(chit[sel] == got.h, {got.rq, " hit flag"}, 32'(chit[sel]), 32'(got.h));
        if (got.cd) chk(crd[sel] == got.d, {got.rq, " read data"}, crd[sel], got.d);
      end
    end
  end

  // Driver: called just after a rising edge
  task automatic acc(input bit we, input logic [3:0] be, input logic [31:0] a,
                     input logic [31:0] wd, input bit eh, input string rq, output int st);
    exp_t e;
    e.h = eh; e.cd = !we; e.d = shadow[sel][a[11:2]]; e.rq = rq;
    q.push_back(e);
    if (we) shadow[sel][a[11:2]] = bmerge(shadow[sel][a[11:2]], wd, be);
    cv[sel] = 1'b1; cwe[sel] = we; cbe[sel] = be; ca[sel] = a; cwd[sel] = wd;
    st = 0;
    @(negedge clk);
    while (!crdy[sel]) begin
      st++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    cv[sel] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st;
    int wc;
    int rc;
    bit pat [8];
    int words [8];
    checks = 0; errors = 0; sel = 0; lat = 4'd2;
    for (int s = 0; s < 2; s++) begin
      cv[s] = 0; cwe[s] = 0; cbe[s] = '0; ca[s] = '0; cwd[s] = '0;
      for (int i = 0; i < 1024; i++) shadow[s][i] = 32'hC0DE_0000 + i;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(crdy[0] == 1'b0 && mreq[0] == 1'b0, "R1 idle after reset", {crdy[0], mreq[0]}, 0);
    chk(crdy[1] == 1'b0 && mreq[1] == 1'b0, "R1 idle after reset wt", {crdy[1], mreq[1]}, 0);
    @(posedge clk); #1;

    // R11 / R1 / R2: hit-miss pattern from cold state (write-back instance)
    words = '{22, 26, 22, 26, 16, 3, 16, 18};
    pat   = '{0, 0, 1, 1, 0, 0, 1, 0};
    foreach (words[i]) acc(0, 4'h0, wa(words[i]), 0, pat[i], "R11 pattern", st);

    // R2: byte offset ignored for lookup
    acc(0, 4'h0, wa(22) + 32'd1, 0, 1, "R2 offset ignored", st);
    acc(0, 4'h0, wa(26) + 32'd3, 0, 0, "R2 tag mismatch line2", st);

    // R4 / R5: cold read miss with longer latency
    lat = 4'd5;
    rc = m0.rd_cnt;
    acc(0, 4'h0, wa(7) + 32'd2, 0, 0, "R4 read miss", st);
    chk(st == 7, "R5 stall cycles", st, 7);
    chk(m0.rd_cnt == rc + 1, "R4 one memory read", m0.rd_cnt, rc + 1);
    chk(m0.last_rd == wa(7), "R4 word address", m0.last_rd, wa(7));
    lat = 4'd2;

    // R6 / R8: write-back store hit, partial bytes
    wc = m0.wr_cnt;
    acc(1, 4'b0101, wa(22), 32'hAABB_CCDD, 1, "R8 store hit", st);
    chk(st == 0, "R8 store completes at once", st, 0);
    chk(m0.wr_cnt == wc, "R8 no memory write", m0.wr_cnt, wc);
    chk(m0.mem[wa(22) >> 2] == 32'hC0DE_0000 + (wa(22) >> 2), "R8 memory untouched",
        m0.mem[wa(22) >> 2], 32'hC0DE_0000 + (wa(22) >> 2));
    acc(0, 4'h0, wa(22), 0, 1, "R6 byte merge readback", st);

    // R9: dirty line replaced
    acc(0, 4'h0, wa(30), 0, 0, "R9 dirty miss", st);
    chk(st == 7, "R9 stall cycles", st, 7);
    chk(m0.wr_cnt == wc + 1, "R9 one writeback", m0.wr_cnt, wc + 1);
    chk(m0.mem[wa(22) >> 2] == shadow[0][wa(22) >> 2], "R9 old word written",
        m0.mem[wa(22) >> 2], shadow[0][wa(22) >> 2]);

    // R10: clean replacement, then store miss allocation
    acc(0, 4'h0, wa(34), 0, 0, "R10 clean miss", st);
    chk(st == 4, "R10 clean stall", st, 4);
    chk(m0.wr_cnt == wc + 1, "R10 no write on clean", m0.wr_cnt, wc + 1);
    acc(1, 4'b1111, wa(5), 32'h1234_5678, 0, "R10 store miss", st);
    acc(0, 4'h0, wa(5), 0, 1, "R10 allocated readback", st);
    chk(m0.mem[5] == 32'hC0DE_0005, "R10 wb store kept in cache", m0.mem[5], 32'hC0DE_0005);

    // Write-through instance
    sel = 1;
    acc(0, 4'h0, wa(40), 0, 0, "R7 cold read", st);
    acc(1, 4'b0011, wa(40), 32'h5566_7788, 1, "R7 store hit", st);
    chk(st == 3, "R7 store hit stall", st, 3);
    chk(m1.wr_cnt == 1, "R7 memory write count", m1.wr_cnt, 1);
    chk(m1.mem[wa(40) >> 2] == shadow[1][wa(40) >> 2], "R7 memory word",
        m1.mem[wa(40) >> 2], shadow[1][wa(40) >> 2]);
    acc(0, 4'h0, wa(40), 0, 1, "R7 readback", st);
    acc(1, 4'b1100, wa(9), 32'h99AA_0000, 0, "R7 store miss", st);
    chk(m1.wr_cnt == 2, "R7 store miss writes", m1.wr_cnt, 2);
    chk(m1.mem[wa(9) >> 2] == shadow[1][wa(9) >> 2], "R6 R7 merged word in memory",
        m1.mem[wa(9) >> 2], shadow[1][wa(9) >> 2]);
    acc(0, 4'h0, wa(9), 0, 1, "R7 store miss readback", st);
    acc(0, 4'h0, wa(48), 0, 0, "R10 wt replacement", st);
    chk(m1.wr_cnt == 2, "R10 wt no eviction write", m1.wr_cnt, 2);

    repeat (3) @(posedge clk);
    chk(q.size() == 0, "R3 all completions seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule